// File: doc/BRIEF.md
# USB Endpoint FIFO Access Arbiter

This block gives the processor a single, polled access path into four small endpoint FIFOs of a USB device. Firmware picks an endpoint with a 3-bit select field and sets a transfer direction. It then raises a request bit, waits for the ready flag, and moves bytes through one shared data port until ready falls. Dropping the request closes the transfer. A transmit transfer hands the stored bytes to the host side. A receive transfer that drained its FIFO returns the endpoint to the host.

The host side is a simple byte port. It can push bytes into an endpoint and close the packet, or pop bytes that firmware queued. Each endpoint has an access flag that is set when the host completes an exchange on it. Firmware reads these flags to find out which endpoint an interrupt came from. A separate sticky flag records a packet of zero length from the host. Any host operation that the endpoint cannot serve is refused with a one-cycle NAK pulse, so an endpoint that firmware has not serviced is answered with NAK.

Top module: `usb_ep_fifo_port`

## Requirements
- R1: After reset, ready, every access flag, the zero-length flag and host_nak are 0, and every FIFO is empty and owned by no side, so a host read on any endpoint is refused.
- R2: ep_sel values 0 to 3 select endpoints 0 to 3. A value of 4 to 7 held when req rises keeps ready at 0 for the whole transfer, and dp_wr and dp_rd then store or remove nothing.
- R3: With dir_tx = 1 when req rises, and the selected endpoint empty with no pending packet, ready is 1 from the clock edge after req rises. Each dp_wr while ready is 1 stores dp_wdata. Ready is 0 after the edge that accepts the DEPTH-th byte. Ready is 0 from the edge after req falls.
- R4: The direction used to close a transfer is the one latched when req rose. When req falls after a transmit transfer that stored at least one byte, host reads of that endpoint return the bytes in write order. Each byte arrives on host_rdata with host_rvalid = 1 in the cycle after the read.
- R5: After the host closes a packet of N > 0 bytes on an endpoint, a receive transfer (dir_tx = 0 at req rise) sees ready = 1. Each dp_rd while ready is 1 returns the next byte on dp_rdata in the following cycle. Ready is 0 after the N-th read. When req falls with the FIFO empty, the endpoint accepts host writes again.
- R6: An accepted host close (host_end) and an accepted host read that removes the last byte each set acc_flags bit ep. Hardware never clears a bit; a 1 on acc_clr bit ep clears it.
- R7: An accepted host close with no bytes stored sets zlp_flag. That flag stays 1 until zlp_clr is 1, and such a packet does not make a receive transfer ready.
- R8: A host operation is refused with host_nak = 1 in the next cycle in three cases. A read is refused on an endpoint holding no queued transmit data. A write or close is refused on an endpoint whose closed packet firmware has not yet drained. Any operation is refused on the endpoint of an active processor transfer.
- R9: A host write to an endpoint already holding DEPTH bytes is refused with host_nak and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_sel | input | SEL_W | Endpoint select field |
| dir_tx | input | 1 | Direction: 1 processor writes, 0 processor reads |
| req | input | 1 | Transfer request; rising opens, falling closes |
| ready | output | 1 | Data port may be used this cycle |
| dp_wr | input | 1 | Data port write strobe |
| dp_wdata | input | DW | Data port write byte |
| dp_rd | input | 1 | Data port read strobe |
| dp_rdata | output | DW | Data port read byte, valid the cycle after dp_rd |
| acc_flags | output | NUM_EP | Per-endpoint host access flags |
| acc_clr | input | NUM_EP | Write-one clear of access flags |
| zlp_flag | output | 1 | Sticky zero-length packet flag |
| zlp_clr | input | 1 | Clear of zlp_flag |
| host_ep | input | EW | Endpoint addressed by the host side |
| host_wr | input | 1 | Host pushes a byte |
| host_wdata | input | DW | Host byte to push |
| host_end | input | 1 | Host closes its packet |
| host_rd | input | 1 | Host pops a byte |
| host_rdata | output | DW | Popped byte |
| host_rvalid | output | 1 | host_rdata valid |
| host_nak | output | 1 | Previous host operation refused |

## Verification
A wrong ownership bit on an endpoint shows up on the next host operation. That operation returns a NAK where data was due, or data where a NAK was due, one cycle after it is issued. A corrupted byte count or pointer shows up as ready falling too early or too late within a single transfer, or as bytes arriving out of order on the scoreboard. A fault in the latched select or direction becomes visible when req falls, as the wrong endpoint becoming readable by the host. A flag that hardware clears by mistake reads 0 in the cycle after the event that cleared it.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic [1:0] {
    H_IDLE = 2'd0,
    H_PUSH = 2'd1,
    H_CLOSE = 2'd2,
    H_POP = 2'd3
  } host_op_e;
endpackage

// File: rtl/ep_fifo.sv
module ep_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic do_wr, do_rd;

  assign do_wr   = wr_en && (cnt != CW'(DEPTH));
  assign do_rd   = rd_en && (cnt != '0);
  assign cnt_nxt = cnt + CW'(do_wr) - CW'(do_rd);

  // storage without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
    if (do_rd) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/ep_cpu_port.sv
module ep_cpu_port #(
  parameter int NUM_EP = 4,
  parameter int DEPTH  = 8,
  parameter int SEL_W  = 3,
  localparam int EW    = $clog2(NUM_EP),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SEL_W-1:0]           ep_sel,
  input  logic                       dir_tx,
  input  logic                       req,
  input  logic                       dp_wr,
  input  logic                       dp_rd,
  input  logic [NUM_EP-1:0][CW-1:0]  cnt_nxt,
  input  logic [NUM_EP-1:0]          host_own,
  input  logic [NUM_EP-1:0]          cpu_own,
  output logic                       ready,
  output logic                       lock_vld,
  output logic [EW-1:0]              lock_ep,
  output logic [NUM_EP-1:0]          fifo_wr,
  output logic [NUM_EP-1:0]          fifo_rd,
  output logic                       end_pulse,
  output logic [EW-1:0]              end_ep,
  output logic                       end_tx
);
  logic          s_on, s_ok, s_tx;
  logic [EW-1:0] s_ep;
  logic          sel_ok, start, stop, eff_tx, ready_d;
  logic [CW-1:0] cn;

  assign sel_ok = int'(ep_sel) < NUM_EP;
  assign start  = req && !s_on;
  assign stop   = !req && s_on;

  // direction and endpoint are frozen at the opening edge
  always_ff @(posedge clk) begin
    if (rst) begin
      s_on <= 1'b0;
      s_ok <= 1'b0;
      s_tx <= 1'b0;
      s_ep <= '0;
    end else if (start) begin
      s_on <= 1'b1;
      s_ok <= sel_ok;
      s_tx <= dir_tx;
      s_ep <= ep_sel[EW-1:0];
    end else if (stop) begin
      s_on <= 1'b0;
    end
  end

  assign lock_vld = s_on ? s_ok : (req && sel_ok);
  assign lock_ep  = s_on ? s_ep : ep_sel[EW-1:0];
  assign eff_tx   = s_on ? s_tx : dir_tx;
  assign cn       = cnt_nxt[lock_ep];

  // ready reflects the state after this edge, so it never lags a transfer
  always_comb begin
    ready_d = 1'b0;
    if (req && lock_vld) begin
      if (eff_tx)
        ready_d = !host_own[lock_ep] && !cpu_own[lock_ep] && (cn != CW'(DEPTH));
      else
        ready_d = cpu_own[lock_ep] && (cn != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ready <= 1'b0;
    else     ready <= ready_d;
  end

  for (genvar i = 0; i < NUM_EP; i++) begin : g_strobe
    assign fifo_wr[i] = s_on && s_ok && s_tx && ready && dp_wr && (s_ep == EW'(i));
    assign fifo_rd[i] = s_on && s_ok && !s_tx && ready && dp_rd && (s_ep == EW'(i));
  end

  assign end_pulse = stop && s_ok;
  assign end_ep    = s_ep;
  assign end_tx    = s_tx;
endmodule

// File: rtl/ep_flags.sv
module ep_flags #(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] acc_set,
  input  logic [NUM_EP-1:0] acc_clr,
  input  logic              zlp_set,
  input  logic              zlp_clr,
  output logic [NUM_EP-1:0] acc_flags,
  output logic              zlp_flag
);
  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_flags <= '0;
      zlp_flag  <= 1'b0;
    end else begin
      acc_flags <= (acc_flags & ~acc_clr) | acc_set;
      zlp_flag  <= (zlp_flag & ~zlp_clr) | zlp_set;
    end
  end
endmodule

// File: rtl/usb_ep_fifo_port.sv
module usb_ep_fifo_port
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DEPTH  = 8,
  parameter int DW     = 8,
  parameter int SEL_W  = 3,
  localparam int EW    = $clog2(NUM_EP),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  ep_sel,
  input  logic              dir_tx,
  input  logic              req,
  output logic              ready,
  input  logic              dp_wr,
  input  logic [DW-1:0]     dp_wdata,
  input  logic              dp_rd,
  output logic [DW-1:0]     dp_rdata,
  output logic [NUM_EP-1:0] acc_flags,
  input  logic [NUM_EP-1:0] acc_clr,
  output logic              zlp_flag,
  input  logic              zlp_clr,
  input  logic [EW-1:0]     host_ep,
  input  logic              host_wr,
  input  logic [DW-1:0]     host_wdata,
  input  logic              host_end,
  input  logic              host_rd,
  output logic [DW-1:0]     host_rdata,
  output logic              host_rvalid,
  output logic              host_nak
);
  logic [NUM_EP-1:0][CW-1:0] cnt, cnt_nxt;
  logic [NUM_EP-1:0][DW-1:0] rdq;
  logic [NUM_EP-1:0] cpu_wr, cpu_rd, h_wr, h_rd, f_wr, f_rd;
  logic [NUM_EP-1:0] host_own, cpu_own, acc_set;
  logic              lock_vld, end_pulse, end_tx;
  logic [EW-1:0]     lock_ep, end_ep, h_ep_q;
  host_op_e          hop;
  logic              h_lock, h_free, ok_wr, ok_end, ok_rd, refuse;
  logic [CW-1:0]     hc;

  ep_cpu_port #(.NUM_EP(NUM_EP), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_cpu (
    .clk(clk), .rst(rst), .ep_sel(ep_sel), .dir_tx(dir_tx), .req(req),
    .dp_wr(dp_wr), .dp_rd(dp_rd), .cnt_nxt(cnt_nxt), .host_own(host_own),
    .cpu_own(cpu_own), .ready(ready), .lock_vld(lock_vld), .lock_ep(lock_ep),
    .fifo_wr(cpu_wr), .fifo_rd(cpu_rd), .end_pulse(end_pulse),
    .end_ep(end_ep), .end_tx(end_tx)
  );

  // host operation decode; push has priority over close, close over pop
  always_comb begin
    if (host_wr)       hop = H_PUSH;
    else if (host_end) hop = H_CLOSE;
    else if (host_rd)  hop = H_POP;
    else               hop = H_IDLE;
  end

  assign hc     = cnt[host_ep];
  assign h_lock = lock_vld && (lock_ep == host_ep);
  assign h_free = !h_lock && !host_own[host_ep] && !cpu_own[host_ep];
  assign ok_wr  = (hop == H_PUSH) && h_free && (hc != CW'(DEPTH));
  assign ok_end = (hop == H_CLOSE) && h_free;
  assign ok_rd  = (hop == H_POP) && !h_lock && host_own[host_ep] && (hc != '0);
  assign refuse = (hop != H_IDLE) && !(ok_wr || ok_end || ok_rd);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic hit;
    assign hit        = (host_ep == EW'(i));
    assign h_wr[i]    = ok_wr && hit;
    assign h_rd[i]    = ok_rd && hit;
    assign f_wr[i]    = cpu_wr[i] || h_wr[i];
    assign f_rd[i]    = cpu_rd[i] || h_rd[i];
    assign acc_set[i] = hit && (ok_end || (ok_rd && hc == CW'(1)));

    ep_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .wr_en(f_wr[i]),
      .wr_data(cpu_wr[i] ? dp_wdata : host_wdata),
      .rd_en(f_rd[i]), .rd_data(rdq[i]), .cnt(cnt[i]), .cnt_nxt(cnt_nxt[i])
    );

    // ownership: host_own = packet queued for the host, cpu_own = for firmware
    always_ff @(posedge clk) begin
      if (rst) begin
        host_own[i] <= 1'b0;
        cpu_own[i]  <= 1'b0;
      end else begin
        if (end_pulse && end_ep == EW'(i)) begin
          if (end_tx && cnt[i] != '0)  host_own[i] <= 1'b1;
          if (!end_tx && cnt[i] == '0) cpu_own[i]  <= 1'b0;
        end
        if (ok_end && hit && hc != '0)    cpu_own[i]  <= 1'b1;
        if (ok_rd && hit && hc == CW'(1)) host_own[i] <= 1'b0;
      end
    end
  end

  ep_flags #(.NUM_EP(NUM_EP)) u_flags (
    .clk(clk), .rst(rst), .acc_set(acc_set), .acc_clr(acc_clr),
    .zlp_set(ok_end && hc == '0), .zlp_clr(zlp_clr),
    .acc_flags(acc_flags), .zlp_flag(zlp_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_nak    <= 1'b0;
      host_rvalid <= 1'b0;
      h_ep_q      <= '0;
    end else begin
      host_nak    <= refuse;
      host_rvalid <= ok_rd;
      h_ep_q      <= host_ep;
    end
  end

  assign host_rdata = rdq[h_ep_q];
  assign dp_rdata   = rdq[end_ep];
endmodule

// File: rtl/usb_ep_fifo_port_chk.sv
module usb_ep_fifo_port_chk #(
  parameter int NUM_EP = 4,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  ep_sel,
  input logic              req,
  input logic              ready,
  input logic [NUM_EP-1:0] acc_flags,
  input logic [NUM_EP-1:0] acc_clr,
  input logic              zlp_flag,
  input logic              zlp_clr,
  input logic              host_wr,
  input logic              host_end,
  input logic              host_rd,
  input logic              host_rvalid,
  input logic              host_nak
);
  assert_ready_drops_R3: assert property (@(posedge clk) disable iff (rst)
    !req |=> !ready);

  assert_bad_sel_R2: assert property (@(posedge clk) disable iff (rst)
    (req && !$past(req) && int'(ep_sel) >= NUM_EP) |=> !ready);

  assert_rvalid_cause_R4: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(host_rd));

  for (genvar i = 0; i < NUM_EP; i++) begin : g_acc
    assert_acc_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (acc_flags[i] && !acc_clr[i]) |=> acc_flags[i]);
  end

  assert_zlp_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (zlp_flag && !zlp_clr) |=> zlp_flag);

  assert_zlp_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(zlp_flag) |-> $past(host_end));

  assert_nak_excl_R8: assert property (@(posedge clk) disable iff (rst)
    host_nak |-> !host_rvalid);

  assert_nak_cause_R8: assert property (@(posedge clk) disable iff (rst)
    host_nak |-> ($past(host_wr) || $past(host_end) || $past(host_rd)));
endmodule

bind usb_ep_fifo_port usb_ep_fifo_port_chk #(.NUM_EP(NUM_EP), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .ep_sel(ep_sel), .req(req), .ready(ready),
  .acc_flags(acc_flags), .acc_clr(acc_clr), .zlp_flag(zlp_flag),
  .zlp_clr(zlp_clr), .host_wr(host_wr), .host_end(host_end),
  .host_rd(host_rd), .host_rvalid(host_rvalid), .host_nak(host_nak)
);

// File: tb/sim_usb_ep_fifo_port.sv
`timescale 1ns/1ps
module sim_usb_ep_fifo_port;
  localparam int NUM_EP = 4, DEPTH = 8, DW = 8, SEL_W = 3, EW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [SEL_W-1:0] ep_sel = '0;
  logic dir_tx = 0, req = 0, ready, dp_wr = 0, dp_rd = 0;
  logic [DW-1:0] dp_wdata = '0, dp_rdata, host_wdata = '0, host_rdata;
  logic [NUM_EP-1:0] acc_flags, acc_clr = '0;
  logic zlp_flag, zlp_clr = 0;
  logic [EW-1:0] host_ep = '0;
  logic host_wr = 0, host_end = 0, host_rd = 0, host_rvalid, host_nak;

  int chk = 0, err = 0;
  logic [DW-1:0] hq[$], cq[$];
  logic rd_live = 0;

  always #2 clk = ~clk;

  usb_ep_fifo_port #(.NUM_EP(NUM_EP), .DEPTH(DEPTH), .DW(DW), .SEL_W(SEL_W)) u0 (
    .clk(clk), .rst(rst), .ep_sel(ep_sel), .dir_tx(dir_tx), .req(req),
    .ready(ready), .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rd(dp_rd),
    .dp_rdata(dp_rdata), .acc_flags(acc_flags), .acc_clr(acc_clr),
    .zlp_flag(zlp_flag), .zlp_clr(zlp_clr), .host_ep(host_ep),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_end(host_end),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .host_nak(host_nak)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    chk++;
    if (!ok) begin
      err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // op: 1 push, 2 close, 3 pop
  task automatic host_do(input int op, input int ep, input int d);
    host_ep = EW'(ep);
    host_wdata = DW'(d);
    host_wr = (op == 1);
    host_end = (op == 2);
    host_rd = (op == 3);
    step();
    host_wr = 0; host_end = 0; host_rd = 0;
  endtask

  task automatic open_xfer(input int sel, input bit tx);
    ep_sel = SEL_W'(sel); dir_tx = tx; req = 1;
    step();
  endtask

  task automatic close_xfer(input bit restore);
    dir_tx = restore;
    step();
    req = 0;
    step();
  endtask

  // scoreboard monitor: compares results mid-cycle against queued expectations
  always begin
    bit take_cpu;
    @(posedge clk);
    take_cpu = rd_live;
    #2;
    if (host_rvalid) begin
      if (hq.size() == 0) check(0, "R4 unexpected host byte", host_rdata, 0);
      else begin
        logic [DW-1:0] e;
        e = hq.pop_front();
        check(host_rdata == e, "R4 host byte", host_rdata, e);
      end
    end
    if (take_cpu) begin
      if (cq.size() == 0) check(0, "R5 unexpected cpu byte", dp_rdata, 0);
      else begin
        logic [DW-1:0] e;
        e = cq.pop_front();
        check(dp_rdata == e, "R5 cpu byte", dp_rdata, e);
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", chk, err);
    $finish;
  endtask

  initial begin
    #800000;
    err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) step();
    rst = 0;
    step();
    // R1 reset state
    check(ready == 0, "R1 ready", ready, 0);
    check(acc_flags == 0, "R1 acc_flags", acc_flags, 0);
    check(zlp_flag == 0, "R1 zlp_flag", zlp_flag, 0);
    check(host_nak == 0, "R1 host_nak", host_nak, 0);
    host_do(3, 2, 0);
    check(host_nak == 1, "R1 read of empty ep naks", host_nak, 1);

    // R3 transmit fill on endpoint 1
    open_xfer(1, 1);
    check(ready == 1, "R3 ready after req", ready, 1);
    host_do(1, 1, 8'hEE);
    check(host_nak == 1, "R8 locked ep naks", host_nak, 1);
    for (int i = 0; i < DEPTH; i++) begin
      dp_wr = 1; dp_wdata = DW'(8'hA0 + i);
      hq.push_back(DW'(8'hA0 + i));
      step();
      dp_wr = 0;
      check(ready == (i < DEPTH - 1), "R3 ready while filling", ready, i < DEPTH - 1);
    end
    // R4 direction restored before req drops; latched direction still commits
    close_xfer(0);
    check(ready == 0, "R3 ready after req falls", ready, 0);
    for (int i = 0; i < DEPTH; i++) host_do(3, 1, 0);
    step();
    check(hq.size() == 0, "R4 all host bytes seen", hq.size(), 0);
    check(acc_flags == 4'b0010, "R6 flag on last pop", acc_flags, 4'b0010);
    host_do(3, 1, 0);
    check(host_nak == 1, "R8 read after drain naks", host_nak, 1);
    acc_clr = 4'b0010; step(); acc_clr = 0;
    check(acc_flags == 0, "R6 clear", acc_flags, 0);

    // R5 host packet on endpoint 2, firmware reads it
    for (int i = 0; i < 3; i++) host_do(1, 2, 8'h30 + i * 7);
    check(host_nak == 0, "R5 host push accepted", host_nak, 0);
    host_do(2, 2, 0);
    check(acc_flags == 4'b0100, "R6 flag on close", acc_flags, 4'b0100);
    check(zlp_flag == 0, "R7 no zlp for data", zlp_flag, 0);
    host_do(1, 2, 8'h11);
    check(host_nak == 1, "R8 unserviced ep naks", host_nak, 1);
    open_xfer(2, 0);
    check(ready == 1, "R5 ready for read", ready, 1);
    for (int i = 0; i < 3; i++) begin
      dp_rd = 1; rd_live = 1;
      cq.push_back(DW'(8'h30 + i * 7));
      step();
      dp_rd = 0; rd_live = 0;
      check(ready == (i < 2), "R5 ready while draining", ready, i < 2);
    end
    close_xfer(1);
    host_do(1, 2, 8'h44);
    check(host_nak == 0, "R5 ep freed after read", host_nak, 0);
    check(cq.size() == 0, "R5 all cpu bytes seen", cq.size(), 0);

    // R7 zero-length packet on endpoint 3
    host_do(2, 3, 0);
    check(zlp_flag == 1, "R7 zlp set", zlp_flag, 1);
    check(acc_flags[3] == 1, "R6 flag on zlp close", acc_flags[3], 1);
    open_xfer(3, 0);
    check(ready == 0, "R7 zlp gives no read data", ready, 0);
    close_xfer(1);
    repeat (3) step();
    check(zlp_flag == 1, "R7 zlp sticky", zlp_flag, 1);
    zlp_clr = 1; step(); zlp_clr = 0;
    check(zlp_flag == 0, "R7 zlp cleared", zlp_flag, 0);

    // R9 overflow on endpoint 0
    for (int i = 0; i < DEPTH; i++) begin
      host_do(1, 0, 8'h5A ^ i);
      check(host_nak == 0, "R9 push within depth", host_nak, 0);
    end
    host_do(1, 0, 8'hFF);
    check(host_nak == 1, "R9 push beyond depth naks", host_nak, 1);
    host_do(2, 0, 0);
    open_xfer(0, 0);
    for (int i = 0; i < DEPTH; i++) begin
      dp_rd = 1; rd_live = 1;
      cq.push_back(DW'(8'h5A ^ i));
      step();
      dp_rd = 0; rd_live = 0;
    end
    check(ready == 0, "R9 only depth bytes stored", ready, 0);
    close_xfer(1);
    step();
    check(cq.size() == 0, "R9 cpu bytes seen", cq.size(), 0);

    // R2 out-of-range select has no effect
    open_xfer(5, 1);
    check(ready == 0, "R2 ready with bad select", ready, 0);
    for (int i = 0; i < 3; i++) begin
      dp_wr = 1; dp_wdata = 8'h77;
      step();
      dp_wr = 0;
      check(ready == 0, "R2 ready stays low", ready, 0);
    end
    close_xfer(0);
    host_do(3, 1, 0);
    check(host_nak == 1, "R2 nothing queued on ep1", host_nak, 1);
    step();
    summary();
  end
endmodule